// File: doc/BRIEF.md
# MDIO management master

This block is a management-interface master that a host processor drives through two 32-bit registers on a plain write/read bus. Software first programs a configuration register with a clock divisor and a preamble enable. It then writes one fully packed management frame word into a frame register. That word holds the start pattern, opcode, device and register address fields, turnaround and write data. The block shifts the word out on the serial management clock and data lines almost verbatim, most significant bit first. If the preamble is enabled, a run of ones goes out ahead of the frame.

For a read frame the master lets go of the data line for the second turnaround bit and the sixteen data bits. It samples the attached device on rising clock edges and returns the sixteen captured bits in the low half of the frame register. A completion flag in the configuration register tells the polling host when the frame has finished. Writing zero to the configuration register switches the engine off.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration register reads 0, the frame register reads 0, the management clock is low and the master does not drive the data line.
- R2: The configuration register sits at offset 0x128. Bits 6:0 hold the divisor and bit 7 enables the preamble; both read back as written. Bit 8 is the completion flag and is read-only: host writes to it have no effect.
- R3: While a frame runs, the management clock toggles every divisor+1 system clocks. A frame of N bits completes exactly 2·N·(divisor+1) clocks after the write that started it. The clock stays low while idle.
- R4: A write to the frame register at offset 0x12C while the engine is idle stores the word. It starts a frame and clears the completion flag only if the engine is enabled and the word is legal: bits 31:30 = 01 and bits 29:28 = 10 (read) or 01 (write). An illegal word is stored but starts nothing.
- R5: With bit 7 set, 32 ones go out before the 32 frame bits. Without it, only the 32 frame bits go out. Frame bits are sent MSB first.
- R6: The data output changes only at the start of a frame or on a falling edge of the management clock.
- R7: On a read frame (bits 29:28 = 10), the master releases the line during frame bits 16 down to 0. At completion, frame register bits 15:0 hold the 16 bits sampled on rising edges during frame bits 15..0, first-sampled bit in bit 15. Bits 31:16 keep the written word.
- R8: On a write frame (bits 29:28 = 01), the master drives the line for every bit. The frame register keeps the written word.
- R9: The completion flag sets when the final bit period ends. Host writes to either register while a frame is busy are ignored.
- R10: Writing zero to the configuration register disables the engine, and a later legal frame word then starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | 12 | Host byte offset for writes and reads |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for the offset on bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | High when the master drives the data line |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The assertions assume that the host holds each write strobe for a single cycle and decodes only the two defined offsets. They also assume that the divisor does not change behind the engine's back during a frame, which the register lock guarantees. The stimulus writes every frame word and configuration through the bus task, one write at a time. The device model drives the line only during the data window of a read frame. Otherwise a pull-up value of one is seen, so no two drivers ever meet on the line.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W   = 12;
    localparam int WORD_W   = 32;
    localparam int DIV_W    = 7;
    localparam int PRE_LEN  = 32;
    localparam int RDAT_W   = 16;
    localparam int CFG_W    = DIV_W + 1;
    localparam int DONE_BIT = CFG_W;

    localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h128;
    localparam logic [ADDR_W-1:0] DATA_OFS = 12'h12C;

    typedef struct packed {
        logic             pre_en;
        logic [DIV_W-1:0] div;
    } cfg_t;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } op_e;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_e;

    function automatic logic frame_ok(input logic [WORD_W-1:0] w);
        return (w[31:30] == 2'b01) &&
               ((w[29:28] == OP_WRITE) || (w[29:28] == OP_READ));
    endfunction

    function automatic logic frame_is_read(input logic [WORD_W-1:0] w);
        return w[29:28] == OP_READ;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          mdc,
    output logic          rise_p,
    output logic          fall_p
);

    logic [DW-1:0] cnt_q;
    logic          wrap_w;

    assign wrap_w = run && (cnt_q == div);
    assign rise_p = wrap_w && !mdc;
    assign fall_p = wrap_w && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap_w) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int FW = WORD_W,
    parameter int PL = PRE_LEN,
    parameter int RW = RDAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [FW-1:0] frame,
    input  logic          pre_en,
    input  logic          rise_p,
    input  logic          fall_p,
    input  logic          mdio_i,
    output logic          busy,
    output logic          done_p,
    output logic          is_read,
    output logic [RW-1:0] cap,
    output logic          mdio_o,
    output logic          mdio_oe
);

    localparam int SH_W = PL + FW;
    localparam int CW   = $clog2(SH_W);
    localparam logic [CW-1:0] LAST_PRE = CW'(SH_W - 1);
    localparam logic [CW-1:0] LAST_FR  = CW'(FW - 1);
    localparam logic [CW-1:0] REL_AT   = CW'(RW);

    eng_state_e      state_q;
    logic [SH_W-1:0] sh_q;
    logic [CW-1:0]   rem_q;
    logic            rd_q;
    logic [RW-1:0]   cap_q;

    assign busy    = (state_q == ENG_SHIFT);
    assign done_p  = busy && fall_p && (rem_q == '0);
    assign is_read = rd_q;
    assign cap     = cap_q;
    assign mdio_o  = busy && sh_q[SH_W-1];
    assign mdio_oe = busy && !(rd_q && (rem_q <= REL_AT));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            sh_q    <= '0;
            rem_q   <= '0;
            rd_q    <= 1'b0;
            cap_q   <= '0;
        end else if (!busy) begin
            if (start) begin
                state_q <= ENG_SHIFT;
                sh_q    <= pre_en ? {{PL{1'b1}}, frame} : {frame, {PL{1'b0}}};
                rem_q   <= pre_en ? LAST_PRE : LAST_FR;
                rd_q    <= frame_is_read(frame);
                cap_q   <= '0;
            end
        end else begin
            if (rise_p && rd_q && (rem_q < REL_AT)) begin
                cap_q <= {cap_q[RW-2:0], mdio_i};
            end
            if (fall_p) begin
                if (rem_q == '0) begin
                    state_q <= ENG_IDLE;
                end else begin
                    sh_q  <= {sh_q[SH_W-2:0], 1'b0};
                    rem_q <= rem_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    cfg_t              cfg_q;
    logic              done_q;
    logic [WORD_W-1:0] data_q;
    logic              wr_ctrl, wr_data, eng_en, start;
    logic              busy, done_p, eng_rd, rise_p, fall_p;
    logic [RDAT_W-1:0] cap;

    assign wr_ctrl = bus_we && (bus_addr == CTRL_OFS) && !busy;
    assign wr_data = bus_we && (bus_addr == DATA_OFS) && !busy;
    assign eng_en  = |cfg_q;
    assign start   = wr_data && eng_en && frame_ok(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);
            end
            if (wr_data) begin
                data_q <= bus_wdata;
            end else if (done_p && eng_rd) begin
                data_q <= {data_q[WORD_W-1:RDAT_W], cap};
            end
            if (start) begin
                done_q <= 1'b0;
            end else if (done_p) begin
                done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFS) begin
            bus_rdata[CFG_W-1:0] = cfg_q;
            bus_rdata[DONE_BIT]  = done_q;
        end else if (bus_addr == DATA_OFS) begin
            bus_rdata = data_q;
        end
    end

    mdio_clkgen #(.DW(DIV_W)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .div    (cfg_q.div),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_engine #(.FW(WORD_W), .PL(PRE_LEN), .RW(RDAT_W)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .frame   (bus_wdata),
        .pre_en  (cfg_q.pre_en),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .done_p  (done_p),
        .is_read (eng_rd),
        .cap     (cap),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              start,
    input logic              done_p,
    input logic              done_q,
    input logic              fall_p,
    input logic              eng_rd,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] data_q,
    input cfg_t              cfg_q
);

    // R3: no clock and no drive while idle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    // R6: output data moves only after a falling clock edge
    p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(fall_p)) |-> $stable(mdio_o));

    // R4: a started frame clears the completion flag
    p_start_clears_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> !done_q);

    // R9: completion sets the flag and frees the engine
    p_done_sets_r9: assert property (@(posedge clk) disable iff (rst)
        done_p |=> (done_q && !busy));

    // R9: frame register locked while busy
    p_data_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_we && (bus_addr == DATA_OFS) && !done_p) |=> $stable(data_q));

    // R9: configuration locked while busy
    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_we && (bus_addr == CTRL_OFS)) |=> $stable(cfg_q));

    // R8: write frames keep the line driven
    p_write_drives_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !eng_rd) |-> mdio_oe);

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .start    (start),
    .done_p   (done_p),
    .done_q   (done_q),
    .fall_p   (fall_p),
    .eng_rd   (eng_rd),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .data_q   (data_q),
    .cfg_q    (cfg_q)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;

    localparam logic [11:0] A_CTRL = 12'h128;
    localparam logic [11:0] A_DATA = 12'h12C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = 12'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        line;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    always_comb line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    mdio_master uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
    );

    // line observer and device model
    logic [63:0] obs_bits = '0;
    logic [63:0] obs_oe = '0;
    int          obs_n = 0;
    int          rk = 0;
    int          cur_pre = 0;
    bit          cur_rd = 0;
    logic [15:0] cur_resp = '0;

    always @(posedge mdc) begin
        obs_bits = {obs_bits[62:0], line};
        obs_oe   = {obs_oe[62:0], mdio_oe};
        obs_n++;
        rk++;
    end

    always @(negedge mdc) begin
        int b;
        b = 31 - (rk - cur_pre);
        if (cur_rd && b >= 0 && b <= 15) begin
            phy_en  = 1'b1;
            phy_bit = cur_resp[b];
        end else begin
            phy_en = 1'b0;
        end
    end

    typedef struct {
        int          n;
        logic [63:0] bits;
        logic [63:0] oe;
        string       tag;
    } exp_t;

    exp_t sb[$];
    event frame_end;

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares the observed line against the queued frame
    initial begin
        forever begin
            @(frame_end);
            if (sb.size() == 0) begin
                check32("R5 queue empty", 32'd0, 32'd1);
            end else begin
                exp_t e;
                logic [63:0] m;
                e = sb.pop_front();
                m = (e.n == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;
                check32({e.tag, " R5 bit count"}, obs_n, e.n);
                check32({e.tag, " R5 bits hi"}, obs_bits[63:32] & m[63:32], e.bits[63:32]);
                check32({e.tag, " R5 bits lo"}, obs_bits[31:0], e.bits[31:0]);
                check32({e.tag, " R7/R8 drive lo"}, obs_oe[31:0], e.oe[31:0]);
                check32({e.tag, " R7/R8 drive hi"}, obs_oe[63:32] & m[63:32], e.oe[63:32]);
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_obs();
        obs_n = 0; obs_bits = '0; obs_oe = '0; rk = 0;
    endtask

    task automatic run_frame(input bit pre, input int div, input logic [31:0] frame,
                             input logic [15:0] resp, input bit poke, input string tag);
        exp_t        e;
        bit          is_rd;
        logic [31:0] lb, lo, cfgv, rd;
        int          t0, n;
        is_rd = (frame[29:28] == 2'b10);
        lb = is_rd ? {frame[31:17], 1'b1, resp} : frame;
        lo = is_rd ? 32'hFFFE_0000 : 32'hFFFF_FFFF;
        n  = pre ? 64 : 32;
        e.n = n; e.tag = tag;
        e.bits = pre ? {32'hFFFF_FFFF, lb} : {32'h0, lb};
        e.oe   = pre ? {32'hFFFF_FFFF, lo} : {32'h0, lo};
        sb.push_back(e);
        cur_pre = pre ? 32 : 0; cur_rd = is_rd; cur_resp = resp;
        clear_obs();
        cfgv = {24'h0, pre, 7'(div)};
        bus_write(A_CTRL, cfgv);
        bus_write(A_DATA, frame);
        t0 = cyc;
        bus_read(A_CTRL, rd);
        check32({tag, " R4 done cleared on start"}, {31'h0, rd[8]}, 32'h0);
        if (poke) begin
            bus_write(A_DATA, 32'h6000_1234);
            bus_write(A_CTRL, 32'h0000_0003);
        end
        do begin
            @(negedge clk);
            bus_read(A_CTRL, rd);
        end while (!rd[8] && (cyc - t0) < 5000);
        check32({tag, " R3 frame duration"}, cyc - t0, n * 2 * (div + 1));
        ->frame_end;
        #1;
        bus_read(A_CTRL, rd);
        check32({tag, " R9 ctrl after frame"}, rd, cfgv | 32'h100);
        bus_read(A_DATA, rd);
        check32({tag, is_rd ? " R7 read data" : " R8 data kept"}, rd,
                is_rd ? {frame[31:16], resp} : frame);
    endtask

    task automatic check_quiet(input string tag);
        bit hi;
        hi = 0;
        repeat (60) begin
            @(negedge clk);
            if (mdc || mdio_oe) hi = 1;
        end
        check32({tag, " no clock activity"}, {31'h0, hi}, 32'h0);
        check32({tag, " no bits shifted"}, obs_n, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] rd;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        bus_read(A_CTRL, rd);
        check32("R1 ctrl reset", rd, 32'h0);
        bus_read(A_DATA, rd);
        check32("R1 data reset", rd, 32'h0);
        check32("R1 mdc/oe reset", {30'h0, mdc, mdio_oe}, 32'h0);

        // R2: configuration readback, completion flag read-only
        bus_write(A_CTRL, 32'h0000_0082);
        bus_read(A_CTRL, rd);
        check32("R2 ctrl readback", rd, 32'h0000_0082);
        bus_write(A_CTRL, 32'h0000_01FF);
        bus_read(A_CTRL, rd);
        check32("R2 done bit read-only", rd, 32'h0000_00FF);

        // main frames
        run_frame(0, 2, 32'h5A4E_BEEF, 16'h0000, 0, "wr nopre div2");
        run_frame(1, 2, 32'h6A9E_0000, 16'hC3A5, 0, "rd pre div2");
        run_frame(1, 0, 32'h6123_0000, 16'h8001, 0, "rd pre div0");
        run_frame(0, 5, 32'h5F03_A55A, 16'h0000, 0, "wr nopre div5");
        run_frame(0, 1, 32'h6C40_FFFF, 16'h7E18, 0, "rd nopre div1");
        // R9: writes during a busy frame are ignored
        run_frame(0, 2, 32'h5555_0F0F, 16'h0000, 1, "R9 busy writes");

        // R4: illegal words are stored but start nothing
        clear_obs();
        bus_write(A_CTRL, 32'h0000_0082);
        bus_write(A_DATA, 32'h7000_0000);
        check_quiet("R4 bad opcode");
        bus_read(A_DATA, rd);
        check32("R4 bad word stored", rd, 32'h7000_0000);
        bus_read(A_CTRL, rd);
        check32("R4 done kept on bad word", rd, 32'h0000_0182);
        bus_write(A_DATA, 32'h9000_0000);
        check_quiet("R4 bad start bits");

        // R10: disabled engine
        bus_write(A_CTRL, 32'h0);
        bus_write(A_DATA, 32'h6A9E_0000);
        check_quiet("R10 disabled");
        bus_read(A_CTRL, rd);
        check32("R10 ctrl disabled", rd, 32'h0000_0100);
        bus_read(A_DATA, rd);
        check32("R10 word stored", rd, 32'h6A9E_0000);

        // re-enable works again after disable
        run_frame(1, 3, 32'h5010_1234, 16'h0000, 0, "R10 re-enable");

        repeat (5) @(negedge clk);
        summary();
    end

endmodule